// File: doc/BRIEF.md
# Fan PWM Generator

This block drives a cooling fan from an 8-bit duty value through an open-drain style pin. The pin is described by two registered outputs. One is a pull-low enable, which pulls the pin to ground when it is 1. The other is the level the pin takes when an external pull-up is present. A polarity control sets whether "fan on" means pulling the pin low or releasing it.

A prescaler divides the system clock by one of two divisors to produce the step rate. The fast divisor is the high base frequency and the slow divisor is the low one. A 64-step period counter advances on each step.

The duty comes from one of two sources. With the program control cleared, it follows an automatic value supplied by a temperature-mapping stage outside the block. With the program control set, it comes from a duty register that the host writes. A small register interface carries the control bits and the manual duty. The block also exports the effective tachometer mode, which is forced to zero while the fast base frequency is selected.

Top module: `fanpwm_gen`

## Requirements
- R1: After a synchronous reset, the control fields hold program=0, polarity=1, clock select=0 and tach mode=00. The manual duty holds 0, pull-low is 0, the pin level is 1, the effective tach mode is 00 and the read data is 0.
- R2: When polarity=1 the pin is pulled low while the fan is on. When polarity=0 the pin is pulled low while the fan is off. The pin level output is always the inverse of pull-low.
- R3: With clock select=0 the period counter advances once every FAST_DIV clocks. With clock select=1 it advances once every SLOW_DIV clocks. The prescaler wraps once its count reaches the selected limit. A PWM period is 64 steps.
- R4: A latched duty d in 0..62 turns the fan on during steps 0..d-1 of each period, so d=0 keeps the fan off.
- R5: A latched duty of 63 or more keeps the fan on for the whole period.
- R6: The selected duty is latched only on the step at which the period counter wraps from 63 to 0. A change of duty during a period has no effect until the next period.
- R7: With program=0 the selected duty is the automatic input. With program=1 it is the manual duty register.
- R8: A write to address 1 (duty) stores its data only while program=1, and is ignored while program=0. A read of address 1 returns the manual duty when program=1 and the automatic input when program=0.
- R9: The effective tach mode output equals the tach mode field when clock select=1, and is 00 when clock select=0.
- R10: The register at address 0 has program at bit 0, polarity at bit 1, clock select at bit 2 and tach mode at bits 4:3. Bits 7:5 read as 0. Read data is registered and reflects the address one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 duty |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| auto_duty | input | 8 | Automatic duty from the temperature mapping stage |
| pin_pull_low | output | 1 | 1 pulls the fan pin to ground |
| pin_level | output | 1 | Pin level with an external pull-up |
| tach_mode_eff | output | 2 | Effective tachometer mode |

## Verification
Two functions can land in the same clock. A period wrap latches a new duty, and in that clock a host write can also flip the program control or polarity, or a new automatic value can arrive. The bench makes these collide by writing to the control register and changing the automatic duty at arbitrary points in the period, including just before a wrap. It also changes the clock select while the prescaler is mid-count. A cycle-level reference model, built from the requirements, predicts which duty source and which polarity each output clock must show. A scoreboard then compares every output clock with that prediction.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
  localparam int DUTY_W = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DUTY = 1'b1;

  typedef struct packed {
    logic [1:0] tmode;
    logic       csel;
    logic       pol;
    logic       prog;
  } fan_ctrl_t;

  localparam int CTRL_W = $bits(fan_ctrl_t);

  localparam fan_ctrl_t CTRL_RST = '{tmode: 2'b00, csel: 1'b0, pol: 1'b1, prog: 1'b0};
endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
  import fanpwm_pkg::*;
#(
  parameter int DW = DUTY_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] auto_duty,
  output fan_ctrl_t     ctrl,
  output logic [DW-1:0] man_duty,
  output logic [DW-1:0] sel_duty,
  output logic [DW-1:0] reg_rdata,
  output logic [1:0]    tach_eff
);
  localparam int PADW = DW - CTRL_W;

  fan_ctrl_t     ctrl_q;
  logic [DW-1:0] man_q;
  logic [DW-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      man_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL)
        ctrl_q <= fan_ctrl_t'(reg_wdata[CTRL_W-1:0]);
      else if (ctrl_q.prog)
        man_q <= reg_wdata;
    end
  end

  assign sel_duty = ctrl_q.prog ? man_q : auto_duty;

  always_comb begin
    if (reg_addr == ADDR_CTRL)
      rd_next = {{PADW{1'b0}}, ctrl_q};
    else
      rd_next = sel_duty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      tach_eff  <= 2'b00;
    end else begin
      reg_rdata <= rd_next;
      tach_eff  <= ctrl_q.csel ? ctrl_q.tmode : 2'b00;
    end
  end

  assign ctrl     = ctrl_q;
  assign man_duty = man_q;
endmodule

// File: rtl/fanpwm_clkdiv.sv
module fanpwm_clkdiv #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_sel,
  output logic tick
);
  localparam int MAXDIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CNT_W  = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_DIV - 1);

  generate
    if (MAXDIV <= 1) begin : g_nodiv
      logic unused_in;
      assign unused_in = clk ^ rst ^ slow_sel;
      assign tick = 1'b1;
    end else begin : g_div
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] lim;
      assign lim  = slow_sel ? SLOW_LIM : FAST_LIM;
      assign tick = (cnt >= lim);
      always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/fanpwm_core.sv
module fanpwm_core #(
  parameter int STEP_W = 6,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [DW-1:0] sel_duty,
  input  logic          pol,
  output logic [DW-1:0] act_duty,
  output logic          period_start,
  output logic          pull_low,
  output logic          level
);
  localparam int PADW = DW - STEP_W;
  localparam logic [STEP_W-1:0] LAST_STEP = {STEP_W{1'b1}};
  localparam logic [DW-1:0]     FULL_ON   = DW'((1 << STEP_W) - 1);

  logic [STEP_W-1:0] step;
  logic [DW-1:0]     act_q;
  logic              fan_on;
  logic              pull_next;

  assign period_start = tick && (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      step  <= '0;
      act_q <= '0;
    end else if (tick) begin
      step <= step + 1'b1;
      if (period_start) act_q <= sel_duty;
    end
  end

  assign fan_on    = (act_q >= FULL_ON) || ({{PADW{1'b0}}, step} < act_q);
  assign pull_next = pol ? fan_on : ~fan_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_low <= 1'b0;
      level    <= 1'b1;
    end else begin
      pull_low <= pull_next;
      level    <= ~pull_next;
    end
  end

  assign act_duty = act_q;
endmodule

// File: rtl/fanpwm_gen.sv
module fanpwm_gen
  import fanpwm_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 5,
  parameter int STEP_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DUTY_W-1:0] reg_wdata,
  output logic [DUTY_W-1:0] reg_rdata,
  input  logic [DUTY_W-1:0] auto_duty,
  output logic              pin_pull_low,
  output logic              pin_level,
  output logic [1:0]        tach_mode_eff
);
  fan_ctrl_t         ctrl;
  logic [DUTY_W-1:0] man_duty;
  logic [DUTY_W-1:0] sel_duty;
  logic [DUTY_W-1:0] act_duty;
  logic              step_tick;
  logic              period_start;
  logic              ctrl_prog;
  logic              ctrl_pol;
  logic              ctrl_csel;

  assign ctrl_prog = ctrl.prog;
  assign ctrl_pol  = ctrl.pol;
  assign ctrl_csel = ctrl.csel;

  fanpwm_regs #(.DW(DUTY_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .auto_duty(auto_duty), .ctrl(ctrl),
    .man_duty(man_duty), .sel_duty(sel_duty), .reg_rdata(reg_rdata),
    .tach_eff(tach_mode_eff)
  );

  fanpwm_clkdiv #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
    .clk(clk), .rst(rst), .slow_sel(ctrl_csel), .tick(step_tick)
  );

  fanpwm_core #(.STEP_W(STEP_W), .DW(DUTY_W)) u_core (
    .clk(clk), .rst(rst), .tick(step_tick), .sel_duty(sel_duty),
    .pol(ctrl_pol), .act_duty(act_duty), .period_start(period_start),
    .pull_low(pin_pull_low), .level(pin_level)
  );
endmodule

// File: rtl/fanpwm_gen_chk.sv
module fanpwm_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic       prog,
  input logic       pol,
  input logic       csel,
  input logic [7:0] man_duty,
  input logic [7:0] act_duty,
  input logic       period_start,
  input logic       pull_low,
  input logic       level,
  input logic [1:0] tach_eff
);
  assert_level_inverse_R2: assert property (@(posedge clk) disable iff (rst)
    level == !pull_low);

  assert_tach_forced_R9: assert property (@(posedge clk) disable iff (rst)
    !csel |=> tach_eff == 2'b00);

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !period_start |=> $stable(act_duty));

  assert_full_on_R5: assert property (@(posedge clk) disable iff (rst)
    (act_duty >= 8'd63) |=> pull_low == $past(pol));

  assert_zero_off_R4: assert property (@(posedge clk) disable iff (rst)
    (act_duty == 8'd0) |=> pull_low == !$past(pol));

  assert_wr_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr && !prog) |=> $stable(man_duty));
endmodule

bind fanpwm_gen fanpwm_gen_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .prog(ctrl_prog), .pol(ctrl_pol), .csel(ctrl_csel),
  .man_duty(man_duty), .act_duty(act_duty), .period_start(period_start),
  .pull_low(pin_pull_low), .level(pin_level), .tach_eff(tach_mode_eff)
);

// File: tb/fanpwm_gen_tb_top.sv
module fanpwm_gen_tb_top;
  localparam int FAST = 2;
  localparam int SLOW = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] auto_duty = 8'h00;
  logic [7:0] reg_rdata;
  logic       pin_pull_low;
  logic       pin_level;
  logic [1:0] tach_mode_eff;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phase = "R1";

  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  fanpwm_gen #(.FAST_DIV(FAST), .SLOW_DIV(SLOW), .STEP_W(6)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .auto_duty(auto_duty),
    .pin_pull_low(pin_pull_low), .pin_level(pin_level),
    .tach_mode_eff(tach_mode_eff)
  );

  // reference model from the requirements
  logic       m_prog, m_pol, m_csel;
  logic [1:0] m_tmode;
  logic [7:0] m_man, m_act, m_sel, m_rd;
  logic [5:0] m_per;
  int         m_pre;

  always @(posedge clk) begin
    logic on, pull, tick;
    int lim;
    if (rst) begin
      m_prog = 0; m_pol = 1; m_csel = 0; m_tmode = 0;
      m_man = 0; m_act = 0; m_per = 0; m_pre = 0;
    end else begin
      on   = (m_act >= 8'd63) || ({2'b00, m_per} < m_act);   // R4 R5
      pull = m_pol ? on : !on;                                // R2
      m_sel = m_prog ? m_man : auto_duty;                     // R7
      m_rd  = reg_addr ? m_sel : {3'b000, m_tmode, m_csel, m_pol, m_prog}; // R10 R8
      exp_q.push_back({pull, !pull, (m_csel ? m_tmode : 2'b00), m_rd});    // R9
      tag_q.push_back(phase);
      lim  = m_csel ? SLOW - 1 : FAST - 1;                    // R3
      tick = (m_pre >= lim);
      if (tick) begin
        if (m_per == 6'd63) m_act = m_sel;                    // R6
        m_per = m_per + 6'd1;
      end
      m_pre = tick ? 0 : m_pre + 1;
      if (reg_wr && reg_addr && m_prog) m_man = reg_wdata;
      if (reg_wr && !reg_addr) {m_tmode, m_csel, m_pol, m_prog} = reg_wdata[4:0];
    end
  end

  // monitor: pops one expected item per output clock
  always @(negedge clk) begin
    logic [11:0] e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks += 4;
      if (pin_pull_low !== e[11]) begin
        errors++;
        $display("FAIL %s pull_low actual=%b expected=%b t=%0t", t, pin_pull_low, e[11], $time);
      end
      if (pin_level !== e[10]) begin
        errors++;
        $display("FAIL R2 pin_level actual=%b expected=%b t=%0t", pin_level, e[10], $time);
      end
      if (tach_mode_eff !== e[9:8]) begin
        errors++;
        $display("FAIL R9 tach actual=%b expected=%b t=%0t", tach_mode_eff, e[9:8], $time);
      end
      if (reg_rdata !== e[7:0]) begin
        errors++;
        $display("FAIL R10 rdata actual=%h expected=%h t=%0t", reg_rdata, e[7:0], $time);
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;   // R1 reset state
    if (pin_pull_low !== 1'b0 || pin_level !== 1'b1 || tach_mode_eff !== 2'b00 || reg_rdata !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset actual=%b%b%b%h expected=0100_00", pin_pull_low, pin_level, tach_mode_eff, reg_rdata);
    end
    rst = 1'b0;
    reg_addr = 1'b0;
    idle(3);                         // R1: control reads 0x02
    phase = "R7"; auto_duty = 8'd16; reg_addr = 1'b1;
    idle(300);
    phase = "R6"; idle(37); auto_duty = 8'd40; idle(60); auto_duty = 8'd5; idle(200);
    phase = "R2"; wr(1'b0, 8'h00); auto_duty = 8'd20; idle(260);
    phase = "R4"; auto_duty = 8'd0; idle(260); auto_duty = 8'd62; idle(260);
    phase = "R5"; auto_duty = 8'd63; idle(200); auto_duty = 8'd200; wr(1'b0, 8'h02); idle(260);
    phase = "R8"; wr(1'b1, 8'd48); reg_addr = 1'b1; idle(4);
    wr(1'b0, 8'h03); reg_addr = 1'b1; idle(140);
    wr(1'b1, 8'd30); auto_duty = 8'd60; idle(260);
    wr(1'b0, 8'h02); reg_addr = 1'b1; idle(150);
    phase = "R3"; auto_duty = 8'd10; wr(1'b0, 8'h16); reg_addr = 1'b0; idle(700);
    wr(1'b0, 8'h19); idle(400);
    wr(1'b0, 8'h1E); idle(7); wr(1'b0, 8'h1A); idle(300);
    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule